// File: doc/BRIEF.md
# Protection Switch Startup Sequencer

This block decides when the pass switch of an input protection stage may be driven on, and supervises the first moments after it is. Two enable pins, one active low and one active high, are combined through a fixed truth table. The result is qualified by the input undervoltage and overvoltage comparators. A qualified request then walks through an input debounce and a gate turn-on delay before the gate enable rises. The debounce is skipped when the output node is already above its own undervoltage level. All intervals are counted in ticks of a free-running 1 µs strobe.

Once the gate is on, the block selects a raised current-limit multiplier for an initial window and then returns to the unit limit. It also watches a comparator that reports the output as charged to within the flag drop of the input. Seeing that comparator in time produces a one-clock startup-done strobe, which a downstream fault-response block uses to sample its mode. Not seeing it before the startup timeout shuts the gate and holds it off until one of the enables or the input comparator changes level. A restart request from a neighbouring protection block (for example after reverse current) forces the gate off and makes the whole sequence, timeout included, run again.

Top module: `switch_start_seq`

## Requirements
- R1: The switch is requested on for every enable pair (hv_en_n, lv_en) except hv_en_n=1 with lv_en=0. With that pair, gate_en is 0 from the following clock on.
- R2: With out_uv_ok low, a qualified request (enable pair on, in_uv_ok=1, in_ov=0) first waits DEB_US ticks of debounce. If the qualification is lost during the debounce, the gate stays off and a later request starts the debounce from zero.
- R3: If out_uv_ok is high when a qualified request leaves idle (fresh enable, or in_ov returning low), the debounce is skipped and only the gate delay is applied.
- R4: gate_en rises only after GATE_DLY_US ticks of gate delay that follow the debounce (or its skip).
- R5: While gate_en is high and fewer than INIT_US ticks have passed since it rose, ilim_mult equals INIT_MULT; otherwise ilim_mult is 2'b00. Encoding: 2'b00 = 1x, 2'b01 = 1.5x, 2'b10 = 2x.
- R6: If out_charged has not been seen within TIMEOUT_US ticks of gate_en rising, the gate turns off. It stays off, regardless of the other inputs, until hv_en_n, lv_en or in_uv_ok changes level. The block then returns to idle.
- R7: start_done is high for exactly one clock: the first clock with the sequencer in the on state, after out_charged was seen during the startup phase. If out_charged arrives in the same clock as the last timeout tick, the start succeeds and no lockout occurs.
- R8: restart_req high, or loss of qualification, forces gate_en to 0 and returns the sequencer to idle (outside lockout). The next start repeats debounce, delay and the full timeout.
- R9: After reset gate_en=0, ilim_mult=2'b00 and start_done=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-clock strobe every microsecond |
| hv_en_n | input | 1 | High-voltage enable, active low |
| lv_en | input | 1 | Low-voltage enable, active high |
| in_uv_ok | input | 1 | Input above its undervoltage threshold |
| in_ov | input | 1 | Input above its overvoltage threshold |
| out_uv_ok | input | 1 | Output above its undervoltage threshold |
| out_charged | input | 1 | Output within the flag drop voltage of the input |
| restart_req | input | 1 | Forces the switch off and restarts the sequence |
| gate_en | output | 1 | Pass-switch gate enable |
| ilim_mult | output | 2 | Current-limit multiplier select |
| start_done | output | 1 | One-clock strobe on successful startup |

## Verification
The charged comparator and the expiry of the startup timeout can both land on the same clock. The order in which they are resolved decides between a good start and a lockout. The bench steers into that clock through its own reference model: it waits until the model shows the last timeout tick pending, then raises out_charged exactly there. It expects the start-done strobe with the gate still on, and the per-clock comparison would show a lockout as a mismatch on gate_en. A second overlap is a toggle of an enable during lockout while qualification remains true; it must release the lockout and restart the debounce in one step.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_DEBOUNCE = 3'd1,
      PH_GATE_DLY = 3'd2,
      PH_RAMP     = 3'd3,
      PH_ON       = 3'd4,
      PH_LOCKOUT  = 3'd5
   } ssq_phase_e;

   localparam logic [1:0] MULT_1X   = 2'b00;
   localparam logic [1:0] MULT_1P5X = 2'b01;
   localparam logic [1:0] MULT_2X   = 2'b10;

endpackage

// File: rtl/ssq_enable_qual.sv
module ssq_enable_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic hv_en_n,
   input  logic lv_en,
   input  logic in_uv_ok,
   input  logic in_ov,
   output logic run_ok,
   output logic retoggle
);

   logic prev_hv_n;
   logic prev_lv;
   logic prev_uv;
   logic pair_on;

   // only the pair (hv_en_n=1, lv_en=0) requests the switch off
   assign pair_on = !hv_en_n || lv_en;
   assign run_ok  = pair_on && in_uv_ok && !in_ov;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_hv_n <= 1'b1;
         prev_lv   <= 1'b0;
         prev_uv   <= 1'b0;
      end else begin
         prev_hv_n <= hv_en_n;
         prev_lv   <= lv_en;
         prev_uv   <= in_uv_ok;
      end
   end

   assign retoggle = (hv_en_n != prev_hv_n) || (lv_en != prev_lv) || (in_uv_ok != prev_uv);

   // R1: an off pair never leaves the qualification true
   p_off_pair_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hv_en_n && !lv_en) |-> !run_ok);

endmodule

// File: rtl/ssq_us_timer.sv
module ssq_us_timer #(
   parameter int MAX_US = 1200000,
   parameter int CNT_W  = $clog2(MAX_US + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_US);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (tick && (cnt != CNT_MAX)) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R6: the elapsed count saturates and never wraps
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/ssq_mult_sel.sv
module ssq_mult_sel
   import ssq_pkg::*;
#(
   parameter int         INIT_US   = 24000,
   parameter logic [1:0] INIT_MULT = MULT_2X,
   parameter int         CNT_W     = 21
) (
   input  logic             gate_on,
   input  logic [CNT_W-1:0] cnt,
   output logic [1:0]       mult
);

   generate
      if (INIT_US == 0) begin : g_no_window
         logic unused_cnt;
         assign unused_cnt = ^cnt;
         assign mult = MULT_1X;
      end else begin : g_window
         localparam logic [CNT_W-1:0] WIN_END = CNT_W'(INIT_US);
         assign mult = (gate_on && (cnt < WIN_END)) ? INIT_MULT : MULT_1X;
      end
   endgenerate

endmodule

// File: rtl/ssq_phase_fsm.sv
module ssq_phase_fsm
   import ssq_pkg::*;
#(
   parameter int DEB_US      = 1200,
   parameter int GATE_DLY_US = 200,
   parameter int TIMEOUT_US  = 1200000,
   parameter int CNT_W       = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_ok,
   input  logic             retoggle,
   input  logic             restart_req,
   input  logic             out_uv_ok,
   input  logic             out_charged,
   input  logic [CNT_W-1:0] cnt,
   output ssq_phase_e       phase,
   output logic             cnt_clr,
   output logic             start_done
);

   localparam logic [CNT_W-1:0] DEB_LAST = CNT_W'(DEB_US - 1);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(GATE_DLY_US - 1);
   localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_US - 1);

   ssq_phase_e phase_nxt;
   logic       done_nxt;
   logic       last_tick;

   always_comb begin
      phase_nxt = phase;
      done_nxt  = 1'b0;
      last_tick = 1'b0;
      if (phase == PH_LOCKOUT) begin
         if (retoggle) phase_nxt = PH_IDLE;
      end else if (!run_ok || restart_req) begin
         phase_nxt = PH_IDLE;
      end else begin
         case (phase)
            PH_IDLE:     phase_nxt = out_uv_ok ? PH_GATE_DLY : PH_DEBOUNCE;
            PH_DEBOUNCE: if (tick && cnt == DEB_LAST) phase_nxt = PH_GATE_DLY;
            PH_GATE_DLY: if (tick && cnt == DLY_LAST) phase_nxt = PH_RAMP;
            PH_RAMP: begin
               last_tick = tick && (cnt == TO_LAST);
               if (out_charged) begin
                  phase_nxt = PH_ON;
                  done_nxt  = 1'b1;
               end else if (last_tick) begin
                  phase_nxt = PH_LOCKOUT;
               end
            end
            default: phase_nxt = phase;
         endcase
      end
   end

   // the elapsed count keeps running from ramp into on for the window
   assign cnt_clr = (phase_nxt != phase) && !(phase == PH_RAMP && phase_nxt == PH_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         start_done <= 1'b0;
      end else begin
         phase      <= phase_nxt;
         start_done <= done_nxt;
      end
   end

   // R7: the strobe lasts one clock and only follows the ramp phase
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_done |=> !start_done);
   p_done_from_ramp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_done |-> ($past(phase) == PH_RAMP && phase == PH_ON));
   // R3: output already up means no debounce
   p_skip_debounce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && run_ok && !restart_req && out_uv_ok) |=> (phase == PH_GATE_DLY));
   // R6: lockout holds until a level change
   p_lockout_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOCKOUT && !retoggle) |=> (phase == PH_LOCKOUT));
   // R8: restart or loss of qualification returns to idle
   p_back_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_LOCKOUT && (!run_ok || restart_req)) |=> (phase == PH_IDLE));

endmodule

// File: rtl/switch_start_seq.sv
module switch_start_seq
   import ssq_pkg::*;
#(
   parameter int         DEB_US      = 1200,
   parameter int         GATE_DLY_US = 200,
   parameter int         INIT_US     = 24000,
   parameter int         TIMEOUT_US  = 1200000,
   parameter logic [1:0] INIT_MULT   = MULT_2X
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic       hv_en_n,
   input  logic       lv_en,
   input  logic       in_uv_ok,
   input  logic       in_ov,
   input  logic       out_uv_ok,
   input  logic       out_charged,
   input  logic       restart_req,
   output logic       gate_en,
   output logic [1:0] ilim_mult,
   output logic       start_done
);

   localparam int CNT_W = $clog2(TIMEOUT_US + 1);

   generate
      if (DEB_US < 1 || GATE_DLY_US < 1 || TIMEOUT_US < 2) begin : g_bad_len
         $error("switch_start_seq: intervals must be at least one tick");
      end
      if (DEB_US > TIMEOUT_US || GATE_DLY_US > TIMEOUT_US || INIT_US > TIMEOUT_US) begin : g_bad_order
         $error("switch_start_seq: no interval may exceed the startup timeout");
      end
      if (INIT_MULT > MULT_2X) begin : g_bad_mult
         $error("switch_start_seq: INIT_MULT must be 1x, 1.5x or 2x");
      end
   endgenerate

   logic             run_ok;
   logic             retoggle;
   logic             cnt_clr;
   logic [CNT_W-1:0] cnt;
   ssq_phase_e       phase;

   ssq_enable_qual u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .hv_en_n  (hv_en_n),
      .lv_en    (lv_en),
      .in_uv_ok (in_uv_ok),
      .in_ov    (in_ov),
      .run_ok   (run_ok),
      .retoggle (retoggle)
   );

   ssq_us_timer #(
      .MAX_US (TIMEOUT_US),
      .CNT_W  (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (tick_us),
      .cnt   (cnt)
   );

   ssq_phase_fsm #(
      .DEB_US      (DEB_US),
      .GATE_DLY_US (GATE_DLY_US),
      .TIMEOUT_US  (TIMEOUT_US),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_us),
      .run_ok      (run_ok),
      .retoggle    (retoggle),
      .restart_req (restart_req),
      .out_uv_ok   (out_uv_ok),
      .out_charged (out_charged),
      .cnt         (cnt),
      .phase       (phase),
      .cnt_clr     (cnt_clr),
      .start_done  (start_done)
   );

   assign gate_en = (phase == PH_RAMP) || (phase == PH_ON);

   ssq_mult_sel #(
      .INIT_US   (INIT_US),
      .INIT_MULT (INIT_MULT),
      .CNT_W     (CNT_W)
   ) u_mult (
      .gate_on (gate_en),
      .cnt     (cnt),
      .mult    (ilim_mult)
   );

   // R1: the off pair turns the gate off on the next clock
   p_gate_off_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hv_en_n && !lv_en) |=> !gate_en);
   // R4: the gate only rises out of the delay phase
   p_gate_after_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> ($past(phase) == PH_GATE_DLY));
   // R5: the multiplier returns to unit when the gate drops
   p_unit_mult_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en) |-> (ilim_mult == MULT_1X));

endmodule

// File: tb/switch_start_seq_test.sv
`timescale 1ns/1ps
module switch_start_seq_test;

   localparam int         P_DEB  = 12;
   localparam int         P_DLY  = 4;
   localparam int         P_INIT = 30;
   localparam int         P_TO   = 60;
   localparam logic [1:0] P_MULT = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic hv_en_n = 1'b1, lv_en = 1'b0, in_uv_ok = 1'b0, in_ov = 1'b0;
   logic out_uv_ok = 1'b0, out_charged = 1'b0, restart_req = 1'b0;
   logic gate_en, start_done;
   logic [1:0] ilim_mult;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string cur_req = "R9";

   switch_start_seq #(
      .DEB_US(P_DEB), .GATE_DLY_US(P_DLY), .INIT_US(P_INIT),
      .TIMEOUT_US(P_TO), .INIT_MULT(P_MULT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .hv_en_n(hv_en_n),
      .lv_en(lv_en), .in_uv_ok(in_uv_ok), .in_ov(in_ov), .out_uv_ok(out_uv_ok),
      .out_charged(out_charged), .restart_req(restart_req),
      .gate_en(gate_en), .ilim_mult(ilim_mult), .start_done(start_done)
   );

   always #5 clk = ~clk;
   initial forever begin
      @(negedge clk);
      tick_us = ~tick_us;
   end

   // behavioural reference: 0 idle, 1 debounce, 2 delay, 3 ramp, 4 on, 5 lockout
   int m_ph, m_us, m_gate, m_mult, m_done;
   logic p_hv, p_lv, p_uv;

   always @(posedge clk) begin
      int np, nd;
      bit want, moved;
      if (!rst_n) begin
         m_ph = 0; m_us = 0; m_gate = 0; m_mult = 0; m_done = 0;
         p_hv = 1'b1; p_lv = 1'b0; p_uv = 1'b0;
      end else begin
         moved = (hv_en_n != p_hv) || (lv_en != p_lv) || (in_uv_ok != p_uv);
         want  = !(hv_en_n && !lv_en) && in_uv_ok && !in_ov;
         np = m_ph; nd = 0;
         if (m_ph == 5) np = moved ? 0 : 5;
         else if (!want || restart_req) np = 0;
         else if (m_ph == 0) np = out_uv_ok ? 2 : 1;
         else if (m_ph == 1 && tick_us && m_us + 1 == P_DEB) np = 2;
         else if (m_ph == 2 && tick_us && m_us + 1 == P_DLY) np = 3;
         else if (m_ph == 3 && out_charged) begin np = 4; nd = 1; end
         else if (m_ph == 3 && tick_us && m_us + 1 == P_TO) np = 5;
         if (np != m_ph && !(m_ph == 3 && np == 4)) m_us = 0;
         else if (tick_us && m_us < P_TO) m_us++;
         m_ph = np;
         m_done = nd;
         m_gate = (np == 3 || np == 4) ? 1 : 0;
         m_mult = (m_gate == 1 && m_us < P_INIT) ? int'(P_MULT) : 0;
         p_hv = hv_en_n; p_lv = lv_en; p_uv = in_uv_ok;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk({cur_req, " gate_en"}, int'(gate_en), m_gate);
         chk({cur_req, " ilim_mult"}, int'(ilim_mult), m_mult);
         chk({cur_req, " start_done"}, int'(start_done), m_done);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic summary;
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      step(5);
      rst_n = 1'b1;
      step(1);
      chk("R9 reset gate", int'(gate_en), 0);
      chk("R9 reset mult", int'(ilim_mult), 0);
      chk("R9 reset done", int'(start_done), 0);

      // R1: off pair holds the gate off, other pairs start it
      cur_req = "R1";
      in_uv_ok = 1'b1; out_uv_ok = 1'b1;
      step(40);
      chk("R1 pair 10 off", int'(gate_en), 0);
      lv_en = 1'b1;
      step(14);
      chk("R1 pair 11 on", int'(gate_en), 1);
      out_charged = 1'b1;
      step(3);
      lv_en = 1'b0;
      step(2);
      chk("R1 pair 10 turns off", int'(gate_en), 0);
      hv_en_n = 1'b0;
      step(14);
      chk("R1 pair 00 on", int'(gate_en), 1);
      lv_en = 1'b1;
      step(4);
      chk("R1 pair 01 on", int'(gate_en), 1);
      hv_en_n = 1'b1; lv_en = 1'b0; out_charged = 1'b0; out_uv_ok = 1'b0;
      step(4);

      // R2: debounce applies when the output is low; abort restarts it
      cur_req = "R2";
      lv_en = 1'b1;
      step(20);
      chk("R2 still debouncing", int'(gate_en), 0);
      step(20);
      chk("R2 on after debounce", int'(gate_en), 1);
      out_charged = 1'b1;
      step(2);
      lv_en = 1'b0; out_charged = 1'b0;
      step(4);
      lv_en = 1'b1;
      step(10);
      in_uv_ok = 1'b0;
      step(2);
      in_uv_ok = 1'b1;
      step(26);
      chk("R2 abort restarts debounce", int'(gate_en), 0);
      step(20);
      chk("R2 on after restarted debounce", int'(gate_en), 1);

      // R5: multiplier window then unit limit
      cur_req = "R5";
      step(2);
      chk("R5 raised multiplier early", int'(ilim_mult), int'(P_MULT));
      out_charged = 1'b1;
      step(70);
      chk("R5 unit multiplier after window", int'(ilim_mult), 0);

      // R3: leaving overvoltage with output up skips debounce; R4 delay
      cur_req = "R3";
      out_uv_ok = 1'b1;
      in_ov = 1'b1;
      step(3);
      chk("R3 off in overvoltage", int'(gate_en), 0);
      in_ov = 1'b0;
      cur_req = "R4";
      step(3);
      chk("R4 gate held during delay", int'(gate_en), 0);
      step(9);
      chk("R3 on without debounce", int'(gate_en), 1);

      // R8: restart request, then the full sequence and timeout again
      cur_req = "R8";
      out_charged = 1'b0; out_uv_ok = 1'b0;
      restart_req = 1'b1;
      step(3);
      chk("R8 restart forces off", int'(gate_en), 0);
      restart_req = 1'b0;
      step(20);
      chk("R8 restart repeats debounce", int'(gate_en), 0);
      step(20);
      chk("R8 restart reaches on", int'(gate_en), 1);
      step(130);
      chk("R8 timeout after restart locks out", int'(gate_en), 0);

      // R6: lockout ignores inputs until a level change
      cur_req = "R6";
      out_charged = 1'b1;
      step(40);
      chk("R6 lockout ignores charged", int'(gate_en), 0);
      out_charged = 1'b0;
      hv_en_n = 1'b0; // pair goes 11 -> 01: still on, but a level change
      step(45);
      chk("R6 toggle releases lockout", int'(gate_en), 1);

      // R7: charged arrives on the very tick that ends the timeout
      cur_req = "R7";
      while (!(m_ph == 3 && m_us == P_TO - 1 && tick_us == 1'b1)) step(1);
      out_charged = 1'b1;
      step(1);
      chk("R7 coincident strobe", int'(start_done), 1);
      chk("R7 coincident gate stays on", int'(gate_en), 1);
      step(1);
      chk("R7 strobe one clock", int'(start_done), 0);
      step(5);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog: actual=running expected=finished");
         summary();
      end
   end

endmodule